// File: doc/BRIEF.md
# Gate pulse width window checker

This block sits between a timing source that produces a beam-gate pulse train and the high-voltage switch that actually chops the beam. It passes the gate through to the switch control. It times every pulse while the pulse is still active and compares the running count against a window. The window is given as a nominal width together with a symmetric tolerance, both counted in clock cycles. At 100 MHz one count is 10 ns, so a window of 100 µs ± 1.2 µs is written as nominal 10000 and tolerance 120.

A pulse that is still high when its count goes beyond nominal plus tolerance trips protection on that same clock edge, so beam is cut without waiting for the pulse to end. A pulse that ends with a count below nominal minus tolerance trips on its falling edge. Any trip latches a fault flag toward the machine-protection interface, together with a 2-bit cause code, and holds the switch gate off. The fault stays latched until a clear strobe is given while the gate input is low.

The gate input passes through a two-flop synchronizer before edges are detected. Configuration writes are taken only while the synchronized gate is low.

Top module: `gate_width_guard`

## Requirements
- R1: After reset, fault is 0, fault_code is 00 and hv_gate_en is 0. The window holds its parameter defaults (nominal 10000, tolerance 120), so a 10000-cycle pulse passes.
- R2: While no fault is latched, hv_gate_en equals gate_in delayed by two clock cycles.
- R3: A pulse of N cycles with nominal−tolerance ≤ N ≤ nominal+tolerance raises no fault. This holds at both limits, and for a zero-tolerance window down to 60-cycle pulses (0.6 µs at 10 ns per count).
- R4: When a pulse stays high beyond nominal+tolerance, fault rises and hv_gate_en falls on the clock edge where the count reaches nominal+tolerance+1. That edge is the (nominal+tolerance+3)th edge after gate_in rises. fault_code becomes 01 (over-width).
- R5: A pulse of N cycles with N < nominal−tolerance sets fault on clock edge N+3 after gate_in rises, with fault_code 10 (under-width).
- R6: Once set, fault and fault_code hold until clear is high at a clock edge where the synchronized gate is low. A clear given while the gate is high is ignored. A clear returns fault_code to 00.
- R7: While fault is set, hv_gate_en is 0 regardless of gate_in.
- R8: A configuration write (cfg_we) while the synchronized gate is high has no effect.
- R9: When the tolerance exceeds the nominal width, the lower limit is 0, so no pulse is under-width.
- R10: The first cause wins. Violations that occur while a fault is latched do not change fault_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst_n | input | 1 | Active-low reset |
| gate_in | input | 1 | Asynchronous beam-gate pulse train |
| cfg_we | input | 1 | Window write strobe |
| cfg_nominal | input | CNT_W | Nominal width in cycles |
| cfg_tolerance | input | CNT_W | Symmetric tolerance in cycles |
| clear | input | 1 | Fault clear strobe |
| hv_gate_en | output | 1 | Gate control to the high-voltage switch |
| fault | output | 1 | Latched protection fault |
| fault_code | output | 2 | 00 none, 01 over-width, 10 under-width |

## Verification
The assertions take for granted that gate_in has already passed through the synchronizer before anything is judged. They watch the synchronized gate, so metastable sampling and sub-cycle glitches on the raw pin are outside their reach. They also assume that pulses stay well below the saturation point of the counter.

The stimulus keeps within these assumptions. It changes gate_in, clear and the configuration only on falling clock edges. It holds each pulse for a whole number of cycles, and it separates pulses by at least four low cycles, so each falling edge is seen before the next rise.

// File: rtl/gate_width_guard.sv
module gate_width_guard #(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] DEF_NOM = 16'd10000,
  parameter logic [CNT_W-1:0] DEF_TOL = 16'd120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_in,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_nominal,
  input  logic [CNT_W-1:0] cfg_tolerance,
  input  logic             clear,
  output logic             hv_gate_en,
  output logic             fault,
  output logic [1:0]       fault_code
);
  localparam int CW = CNT_W + 1;
  localparam logic [1:0] CODE_NONE  = 2'b00;
  localparam logic [1:0] CODE_OVER  = 2'b01;
  localparam logic [1:0] CODE_UNDER = 2'b10;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   gate_s, gate_d;
  logic [CNT_W-1:0]       nom_q, tol_q;
  logic [CW-1:0]          cnt_q, cnt_nxt, upper, lower;
  logic                   rising, falling, over_trip, under_trip;
  logic                   fault_q;
  logic [1:0]             code_q;

  assign gate_s  = sync_q[SYNC_STAGES-1];
  assign rising  = gate_s & ~gate_d;
  assign falling = ~gate_s & gate_d;

  assign upper = {1'b0, nom_q} + {1'b0, tol_q};
  assign lower = (tol_q > nom_q) ? '0 : {1'b0, nom_q - tol_q};

  assign cnt_nxt    = rising ? CW'(1) : ((&cnt_q) ? cnt_q : cnt_q + 1'b1);
  assign over_trip  = gate_s && (cnt_nxt > upper);
  assign under_trip = falling && (cnt_q < lower);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      gate_d <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], gate_in};
      gate_d <= gate_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nom_q <= DEF_NOM;
      tol_q <= DEF_TOL;
    end else if (cfg_we && !gate_s) begin
      nom_q <= cfg_nominal;
      tol_q <= cfg_tolerance;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (gate_s) cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      code_q  <= CODE_NONE;
    end else if (!fault_q) begin
      if (over_trip) begin
        fault_q <= 1'b1;
        code_q  <= CODE_OVER;
      end else if (under_trip) begin
        fault_q <= 1'b1;
        code_q  <= CODE_UNDER;
      end
    end else if (clear && !gate_s) begin
      fault_q <= 1'b0;
      code_q  <= CODE_NONE;
    end
  end

  assign hv_gate_en = gate_s & ~fault_q;
  assign fault      = fault_q;
  assign fault_code = code_q;
endmodule

// File: rtl/gate_width_guard_chk.sv
module gate_width_guard_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_s,
  input logic             clear,
  input logic             fault,
  input logic [1:0]       fault_code,
  input logic             hv_gate_en,
  input logic [CNT_W:0]   cnt_q,
  input logic [CNT_W:0]   upper,
  input logic [CNT_W-1:0] nom_q,
  input logic [CNT_W-1:0] tol_q
);
  AST_GATE_OFF_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !hv_gate_en); // R7

  AST_CODE_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_code == 2'b00) == !fault) && (fault_code != 2'b11)); // R6

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !(clear && !gate_s) |=> fault && $stable(fault_code)); // R10

  AST_CLEAR_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> $past(clear) && !$past(gate_s)); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    gate_s |=> $stable(nom_q) && $stable(tol_q)); // R8

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    hv_gate_en && $past(hv_gate_en) |-> cnt_q <= upper); // R4
endmodule

bind gate_width_guard gate_width_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_s(gate_s), .clear(clear),
  .fault(fault), .fault_code(fault_code), .hv_gate_en(hv_gate_en),
  .cnt_q(cnt_q), .upper(upper), .nom_q(nom_q), .tol_q(tol_q)
);

// File: tb/test_gate_width_guard.sv
module test_gate_width_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate_in = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_nominal = '0;
  logic [15:0] cfg_tolerance = '0;
  logic        clear = 1'b0;
  logic        hv_gate_en, fault;
  logic [1:0]  fault_code;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gate_width_guard i_gate_width_guard (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .cfg_we(cfg_we),
    .cfg_nominal(cfg_nominal), .cfg_tolerance(cfg_tolerance), .clear(clear),
    .hv_gate_en(hv_gate_en), .fault(fault), .fault_code(fault_code)
  );

  localparam int NV = 8;
  localparam int V_NOM[NV]  = '{100, 100, 100, 100, 100, 60, 60, 60};
  localparam int V_TOL[NV]  = '{12, 12, 12, 12, 12, 0, 0, 0};
  localparam int V_W[NV]    = '{100, 112, 113, 88, 87, 60, 59, 61};
  localparam int V_CODE[NV] = '{0, 0, 1, 0, 2, 0, 2, 1};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic write_cfg(int nom, int tol);
    @(negedge clk);
    cfg_we = 1'b1; cfg_nominal = 16'(nom); cfg_tolerance = 16'(tol);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); gate_in = 1'b1;
    repeat (n) @(negedge clk);
    gate_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fault", fault, 0);
    check("R1 code", fault_code, 0);
    check("R1 gate_en", hv_gate_en, 0);
    pulse(10000);
    check("R1 default window", fault_code, 0);

    for (int i = 0; i < NV; i++) begin
      do_clear();
      write_cfg(V_NOM[i], V_TOL[i]);
      pulse(V_W[i]);
      check(V_CODE[i] == 0 ? "R3 window vector" :
            (V_CODE[i] == 1 ? "R4 over vector" : "R5 under vector"),
            fault_code, V_CODE[i]);
    end

    // R2, R4, R6, R7: over-width timing, window 10 +- 2
    do_clear();
    write_cfg(10, 2);
    @(negedge clk); gate_in = 1'b1;
    @(negedge clk);
    check("R2 latency edge1", hv_gate_en, 0);
    @(negedge clk);
    check("R2 latency edge2", hv_gate_en, 1);
    repeat (12) @(negedge clk);
    check("R4 no trip at limit", fault, 0);
    check("R2 forwarding", hv_gate_en, 1);
    @(negedge clk);
    check("R4 trip edge fault", fault, 1);
    check("R4 trip edge gate_en", hv_gate_en, 0);
    check("R4 code", fault_code, 1);
    clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    @(negedge clk);
    check("R6 clear ignored while high", fault, 1);
    check("R7 gate held off", hv_gate_en, 0);
    gate_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 held after fall", fault, 1);
    do_clear();
    check("R6 cleared", fault, 0);
    check("R6 code cleared", fault_code, 0);

    // R5, R10: under-width timing then a later violation
    @(negedge clk); gate_in = 1'b1;
    repeat (5) @(negedge clk);
    gate_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R5 before edge", fault, 0);
    @(negedge clk);
    check("R5 trip edge", fault, 1);
    check("R5 code", fault_code, 2);
    @(negedge clk); gate_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 gate off during pulse", hv_gate_en, 0);
    repeat (26) @(negedge clk);
    gate_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 first cause kept", fault_code, 2);

    // R8: write during an active pulse is ignored
    do_clear();
    write_cfg(20, 0);
    @(negedge clk); gate_in = 1'b1;
    repeat (3) @(negedge clk);
    cfg_we = 1'b1; cfg_nominal = 16'd5; cfg_tolerance = 16'd0;
    @(negedge clk); cfg_we = 1'b0;
    repeat (16) @(negedge clk);
    gate_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 write while high ignored", fault_code, 0);
    pulse(20);
    check("R8 window unchanged", fault_code, 0);

    // R9: tolerance above nominal
    write_cfg(3, 10);
    pulse(1);
    check("R9 lower floor zero", fault_code, 0);
    pulse(13);
    check("R9 upper limit passes", fault_code, 0);
    pulse(14);
    check("R9 over upper", fault_code, 1);

    finish_run();
  end
endmodule